// File: doc/BRIEF.md
# Asynchronous Backplane Transfer Handshake

This block carries single read and write cycles across a parallel backplane on which no clock is shared. A local client hands a command to the master side over a valid/ready stream. The master then places the address, an address-modifier code, the direction and, for writes, the data on the backplane, and raises its address and data strobes. The slave side decodes the address and the modifier code. A slave that accepts the cycle answers with a transfer acknowledge. A slave that recognises the cycle but cannot complete it answers with a bus error. A slave that does not recognise the cycle stays silent. Every phase advances only on strobe and response edges. Both sides run in a synchronous fabric and bring in each other's lines through two-flop synchronisers.

The handshake has four phases. The master withdraws its strobes once it sees a response, and the slave withdraws its response only once it sees the strobes fall. If no response arrives within the number of cycles on `tmo_limit`, the master ends the cycle with a timeout status. The outcome comes back on a valid/ready response stream. Back-pressure rules: a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that point until the matching response has been taken. A response is held, unchanged, while `rsp_valid` is high and `rsp_ready` is low.

The slave here holds `NREG` data words. Its decode window is the 16-word block whose upper address bits equal those of `BASE` (0x40 by default). It supports the modifier codes 1 and 2.

Top module: `async_xfer_link`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and both strobes and both slave responses on the backplane are 0.
- R2: A write inside the window, to word offset below NREG (offset = address bits [3:0]), with modifier code 1 or 2, ends with status 0 (ok), and a later read of the same address returns the written data.
- R3: A read inside the window, to an offset below NREG, with a supported modifier, ends with status 0 and returns the stored word. The slave's data is valid and stable for the whole time its acknowledge is high.
- R4: An access inside the window to an offset of NREG or more, with a supported modifier, ends with status 1 (bus error) and leaves every stored word unchanged.
- R5: An address outside the window, or a modifier code other than 1 or 2, gets no response from the slave. The cycle ends with status 2 (timeout), and a write of this kind changes no stored word.
- R6: A timed-out cycle lasts longer by exactly N clock cycles when `tmo_limit` is raised by N.
- R7: The master drops its strobes only after a response. The slave drops its response only while the strobes are low. A new cycle never raises the address strobe while a response line is still high.
- R8: Acknowledge and bus error are never high together.
- R9: Address, modifier, direction and write data stay stable for as long as the address strobe is held.
- R10: Stream rules: `cmd_ready` falls after a command is taken and stays low while the strobe is up. A response waiting on `rsp_ready` keeps `rsp_valid`, status and data unchanged.
- R11: The slave reacts only to strobes that have passed its two-flop synchroniser. An acknowledge never rises unless the address strobe was already high two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock for both sides |
| rst_n | input | 1 | Active-low reset |
| tmo_limit | input | TMOW | Response wait limit in cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_am | input | AMW | Address-modifier code |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_status | output | 2 | 0 ok, 1 bus error, 2 timeout |
| rsp_rdata | output | DW | Read data (valid for status 0 reads) |

## Verification
The assertions watch every cycle for the backplane handshake: the two responses never overlap, the address and data hold while the strobe is up, the ordering of strobe and response edges, the response shows the synchroniser delay, read data holds under acknowledge, and the stream rules at both ends. Only the bench's scenarios can show what each cycle produces. That covers which offsets and modifier codes give ok, bus error or silence, that stored words survive refused and ignored writes, and that the timeout length follows `tmo_limit` one cycle per count. The bench sweeps every offset of the window, all eight modifier codes, and addresses on both sides of the window, against a word model of its own.

// File: rtl/abx_pkg.sv
package abx_pkg;
  typedef enum logic [1:0] {
    XS_OK   = 2'd0,
    XS_BERR = 2'd1,
    XS_TMO  = 2'd2
  } xfer_status_e;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_STRB,
    M_REL,
    M_RESP
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_HOLD
  } slv_state_e;
endpackage

// File: rtl/abx_sync2.sv
module abx_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/abx_master.sv
module abx_master
  import abx_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int AMW  = 3,
  parameter int TMOW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TMOW-1:0] tmo_limit,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_write,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [AMW-1:0]  cmd_am,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_status,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [AMW-1:0]  bus_am,
  output logic            bus_write,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_as,
  output logic            bus_ds,
  input  logic            ack_s,
  input  logic            err_s,
  input  logic [DW-1:0]   bus_rdata
);
  mst_state_e      st;
  logic [TMOW-1:0] wait_cnt;

  assign cmd_ready = (st == M_IDLE);
  assign rsp_valid = (st == M_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_IDLE;
      wait_cnt   <= '0;
      bus_addr   <= '0;
      bus_am     <= '0;
      bus_write  <= 1'b0;
      bus_wdata  <= '0;
      bus_as     <= 1'b0;
      bus_ds     <= 1'b0;
      rsp_status <= XS_OK;
      rsp_rdata  <= '0;
    end else begin
      unique case (st)
        M_IDLE: if (cmd_valid) begin
          bus_addr  <= cmd_addr;
          bus_am    <= cmd_am;
          bus_write <= cmd_write;
          bus_wdata <= cmd_wdata;
          st        <= M_ADDR;
        end
        M_ADDR: begin
          bus_as   <= 1'b1;
          bus_ds   <= 1'b1;
          wait_cnt <= '0;
          st       <= M_STRB;
        end
        M_STRB: begin
          if (ack_s) begin
            rsp_status <= XS_OK;
            if (!bus_write) rsp_rdata <= bus_rdata;
            bus_as <= 1'b0;
            bus_ds <= 1'b0;
            st     <= M_REL;
          end else if (err_s) begin
            rsp_status <= XS_BERR;
            bus_as <= 1'b0;
            bus_ds <= 1'b0;
            st     <= M_REL;
          end else if (wait_cnt == tmo_limit) begin
            rsp_status <= XS_TMO;
            bus_as <= 1'b0;
            bus_ds <= 1'b0;
            st     <= M_REL;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        M_REL: if (!ack_s && !err_s) st <= M_RESP;
        M_RESP: if (rsp_ready) st <= M_IDLE;
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abx_slave.sv
module abx_slave
  import abx_pkg::*;
#(
  parameter int          AW    = 8,
  parameter int          DW    = 8,
  parameter int          AMW   = 3,
  parameter logic [AW-1:0] BASE = 8'h40,
  parameter int          WINW  = 4,
  parameter int          NREG  = 4,
  parameter int          LAT   = 2,
  parameter logic [AMW-1:0] AM_A = 3'd1,
  parameter logic [AMW-1:0] AM_B = 3'd2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [AMW-1:0] bus_am,
  input  logic           bus_write,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           as_s,
  input  logic           ds_s,
  output logic           bus_dtack,
  output logic           bus_berr,
  output logic [DW-1:0]  bus_rdata
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int LATW = $clog2(LAT + 2);

  slv_state_e      st;
  logic [LATW-1:0] lat_cnt;
  logic [DW-1:0]   words [NREG];
  logic            hit;
  logic            in_range;
  logic [WINW-1:0] offs;
  logic [IDXW-1:0] idx;

  assign offs     = bus_addr[WINW-1:0];
  assign idx      = offs[IDXW-1:0];
  assign in_range = (32'(offs) < NREG);
  assign hit      = (bus_addr[AW-1:WINW] == BASE[AW-1:WINW]) &&
                    ((bus_am == AM_A) || (bus_am == AM_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lat_cnt   <= '0;
      bus_dtack <= 1'b0;
      bus_berr  <= 1'b0;
      bus_rdata <= '0;
      for (int i = 0; i < NREG; i++) words[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (as_s && ds_s && hit) begin
          lat_cnt <= '0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (!as_s) begin
            st <= S_IDLE;
          end else if (lat_cnt == LATW'(LAT)) begin
            if (in_range) begin
              if (bus_write) words[idx] <= bus_wdata;
              else           bus_rdata  <= words[idx];
              bus_dtack <= 1'b1;
            end else begin
              bus_berr <= 1'b1;
            end
            st <= S_HOLD;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        S_HOLD: if (!as_s) begin
          bus_dtack <= 1'b0;
          bus_berr  <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_xfer_link.sv
module async_xfer_link #(
  parameter int             AW    = 8,
  parameter int             DW    = 8,
  parameter int             AMW   = 3,
  parameter int             TMOW  = 8,
  parameter logic [AW-1:0]  BASE  = 8'h40,
  parameter int             WINW  = 4,
  parameter int             NREG  = 4,
  parameter int             LAT   = 2,
  parameter logic [AMW-1:0] AM_A  = 3'd1,
  parameter logic [AMW-1:0] AM_B  = 3'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TMOW-1:0] tmo_limit,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_write,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [AMW-1:0]  cmd_am,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_status,
  output logic [DW-1:0]   rsp_rdata
);
  logic [AW-1:0]  bus_addr;
  logic [AMW-1:0] bus_am;
  logic           bus_write;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic           bus_as, bus_ds;
  logic           bus_dtack, bus_berr;
  logic           as_s, ds_s, ack_s, err_s;

  abx_master #(.AW(AW), .DW(DW), .AMW(AMW), .TMOW(TMOW)) u_mst (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_am(cmd_am), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_am(bus_am), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_as(bus_as), .bus_ds(bus_ds),
    .ack_s(ack_s), .err_s(err_s), .bus_rdata(bus_rdata)
  );

  abx_sync2 #(.W(2)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({bus_as, bus_ds}), .q({as_s, ds_s})
  );

  abx_sync2 #(.W(2)) u_sync_resp (
    .clk(clk), .rst_n(rst_n), .d({bus_dtack, bus_berr}), .q({ack_s, err_s})
  );

  abx_slave #(
    .AW(AW), .DW(DW), .AMW(AMW), .BASE(BASE), .WINW(WINW),
    .NREG(NREG), .LAT(LAT), .AM_A(AM_A), .AM_B(AM_B)
  ) u_slv (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_am(bus_am),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .as_s(as_s), .ds_s(ds_s),
    .bus_dtack(bus_dtack), .bus_berr(bus_berr), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/abx_checker.sv
module abx_checker #(
  parameter int             AW   = 8,
  parameter int             DW   = 8,
  parameter int             AMW  = 3,
  parameter logic [AW-1:0]  BASE = 8'h40,
  parameter int             WINW = 4,
  parameter logic [AMW-1:0] AM_A = 3'd1,
  parameter logic [AMW-1:0] AM_B = 3'd2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [1:0]     rsp_status,
  input logic [DW-1:0]  rsp_rdata,
  input logic [AW-1:0]  bus_addr,
  input logic [AMW-1:0] bus_am,
  input logic           bus_write,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic           bus_as,
  input logic           bus_dtack,
  input logic           bus_berr
);
  logic decoded;
  assign decoded = (bus_addr[AW-1:WINW] == BASE[AW-1:WINW]) &&
                   ((bus_am == AM_A) || (bus_am == AM_B));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> cmd_ready && !rsp_valid && !bus_as && !bus_dtack && !bus_berr);

  // R8
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_dtack && bus_berr));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as && $past(bus_as) |-> $stable(bus_addr) && $stable(bus_am) &&
                                $stable(bus_write) && $stable(bus_wdata));

  // R7
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as) |-> !bus_dtack && !bus_berr);

  // R7
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as) |-> $past(bus_dtack) || $past(bus_berr) || !decoded);

  // R7
  resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_dtack) || $fell(bus_berr)) |-> !bus_as);

  // R5
  silent_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_dtack) || $rose(bus_berr)) |-> decoded && bus_as);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dtack && $past(bus_dtack) && !bus_write |-> $stable(bus_rdata));

  // R11
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dtack) |-> $past(bus_as, 2));

  // R10
  cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> !cmd_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_rdata));
endmodule

bind async_xfer_link abx_checker #(
  .AW(AW), .DW(DW), .AMW(AMW), .BASE(BASE), .WINW(WINW), .AM_A(AM_A), .AM_B(AM_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_am(bus_am),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_as(bus_as), .bus_dtack(bus_dtack), .bus_berr(bus_berr)
);

// File: tb/sim_async_xfer_link.sv
module sim_async_xfer_link;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tmo_limit = 8'd20;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic [2:0] cmd_am = '0;
  logic [7:0] cmd_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [1:0] rsp_status;
  logic [7:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  async_xfer_link u0 (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_am(cmd_am), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [2:0] am,
                      input logic [7:0] wd, input int hold,
                      output logic [1:0] st, output logic [7:0] rd, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_am = am; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R10 ready low after take", int'(cmd_ready), 0);
    cyc = 0;
    while (!rsp_valid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    st = rsp_status;
    rd = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == st && rsp_rdata == rd,
          "R10 response held under back-pressure", int'(rsp_valid), 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    logic [1:0] st;
    logic [7:0] rd;
    int cyc, cyc_a, cyc_b;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R1 idle during reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R1 idle after reset", int'(rsp_valid), 0);

    // R2: write every word with both supported modifier codes, read back
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 4; i++) begin
        logic [7:0] v;
        v = 8'((i * 37 + k * 91 + 5) & 255);
        xfer(1'b1, 8'h40 | 8'(i), 3'(k + 1), v, 0, st, rd, cyc);
        chk(st == 2'd0, "R2 write status", int'(st), 0);
        model[i] = v;
      end
      for (int i = 0; i < 4; i++) begin
        xfer(1'b0, 8'h40 | 8'(i), 3'(2 - k), 8'h00, 0, st, rd, cyc);
        chk(st == 2'd0, "R3 read status", int'(st), 0);
        chk(rd == model[i], "R2 readback data", int'(rd), int'(model[i]));
      end
    end

    // R4: sweep the whole window with reads and writes
    for (int off = 0; off < 16; off++) begin
      xfer(1'b1, 8'h40 | 8'(off), 3'd1, 8'hEE, 0, st, rd, cyc);
      if (off < 4) model[off] = 8'hEE;
      chk(st == ((off < 4) ? 2'd0 : 2'd1), "R4 write status by offset", int'(st), (off < 4) ? 0 : 1);
      xfer(1'b0, 8'h40 | 8'(off), 3'd2, 8'h00, 0, st, rd, cyc);
      chk(st == ((off < 4) ? 2'd0 : 2'd1), "R4 read status by offset", int'(st), (off < 4) ? 0 : 1);
      if (off < 4) chk(rd == model[off], "R3 read data by offset", int'(rd), int'(model[off]));
    end
    for (int i = 0; i < 4; i++) begin
      xfer(1'b1, 8'h40 | 8'(i), 3'd1, 8'(16 * i + 3), 0, st, rd, cyc);
      model[i] = 8'(16 * i + 3);
    end
    for (int off = 4; off < 16; off++)
      xfer(1'b1, 8'h40 | 8'(off), 3'd2, 8'h77, 0, st, rd, cyc);
    for (int i = 0; i < 4; i++) begin
      xfer(1'b0, 8'h40 | 8'(i), 3'd1, 8'h00, 0, st, rd, cyc);
      chk(rd == model[i], "R4 words unchanged after bus errors", int'(rd), int'(model[i]));
    end

    // R5: every modifier code, writes then read back
    for (int am = 0; am < 8; am++) begin
      bit sup;
      sup = (am == 1) || (am == 2);
      xfer(1'b1, 8'h42, 3'(am), 8'(am * 17 + 1), 0, st, rd, cyc);
      if (sup) model[2] = 8'(am * 17 + 1);
      chk(st == (sup ? 2'd0 : 2'd2), "R5 status by modifier", int'(st), sup ? 0 : 2);
      xfer(1'b0, 8'h42, 3'd1, 8'h00, 0, st, rd, cyc);
      chk(rd == model[2], "R5 word after modifier write", int'(rd), int'(model[2]));
    end

    // R5: addresses outside the window
    foreach (model[i]) begin end
    for (int j = 0; j < 6; j++) begin
      logic [7:0] a;
      case (j)
        0: a = 8'h00; 1: a = 8'h3F; 2: a = 8'h50;
        3: a = 8'hC1; 4: a = 8'h80; default: a = 8'h01;
      endcase
      xfer(1'b1, a, 3'd1, 8'h5A, 0, st, rd, cyc);
      chk(st == 2'd2, "R5 outside window times out", int'(st), 2);
    end
    for (int i = 0; i < 4; i++) begin
      xfer(1'b0, 8'h40 | 8'(i), 3'd2, 8'h00, 0, st, rd, cyc);
      chk(rd == model[i], "R5 words unchanged after ignored writes", int'(rd), int'(model[i]));
    end

    // R6: timeout length follows tmo_limit
    tmo_limit = 8'd10;
    xfer(1'b0, 8'h90, 3'd1, 8'h00, 0, st, rd, cyc_a);
    tmo_limit = 8'd30;
    xfer(1'b0, 8'h90, 3'd1, 8'h00, 0, st, rd, cyc_b);
    chk(cyc_b - cyc_a == 20, "R6 timeout scales with limit", cyc_b - cyc_a, 20);
    tmo_limit = 8'd55;
    xfer(1'b0, 8'h40, 3'd5, 8'h00, 0, st, rd, cyc);
    chk(cyc - cyc_b == 25, "R6 timeout scales with limit (2)", cyc - cyc_b, 25);
    tmo_limit = 8'd20;

    // R10: back-pressure on each ending
    xfer(1'b0, 8'h43, 3'd1, 8'h00, 4, st, rd, cyc);
    chk(st == 2'd0 && rd == model[3], "R10 held ok response", int'(rd), int'(model[3]));
    xfer(1'b0, 8'h47, 3'd1, 8'h00, 3, st, rd, cyc);
    chk(st == 2'd1, "R10 held bus error response", int'(st), 1);
    xfer(1'b0, 8'h20, 3'd1, 8'h00, 2, st, rd, cyc);
    chk(st == 2'd2, "R10 held timeout response", int'(st), 2);

    // R7 R8 R9 R11 are watched by the bound checker throughout
    repeat (5) @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R7 link idle at end", int'(cmd_ready), 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule